// File: doc/BRIEF.md
# Byte-Stream CRC Framer and Checker

This block protects byte-wide payloads that travel over a serial peripheral link with a cyclic redundancy check. On the transmit side it takes payload bytes through a valid/last/ready handshake and forwards each one a cycle later. After the final payload byte it appends the checksum as a trailer. On the receive side it consumes the payload bytes, then the trailer, and reports whether the two agree.

One byte is absorbed per clock. A static parameter `CRC_W` picks the checksum variant. With 8 the polynomial is 0x07 and the register starts at 0x00. With 16 the polynomial is 0x1021 and the register starts at 0xFFFF. The running register returns to its start value on its own after each frame's last payload byte, so frames may follow each other with no idle cycle. Either side can also be restarted mid-stream with a one-cycle frame-start pulse.

Top module: `crc_frame_engine`

## Requirements
- R1: With `CRC_W`=8, the register starts at 0x00. Each byte is XORed into it, then eight MSB-first shift steps follow, and a step XORs 0x07 in only when the top bit was 1 before the shift. The nine ASCII bytes "123456789" give the trailer 0xF4.
- R2: With `CRC_W`=16, the register starts at 0xFFFF. Each byte is XORed into bits 15:8, then eight MSB-first steps with polynomial 0x1021 follow, and the result is kept to 16 bits. "123456789" gives 0x29B1, on both the transmit and the receive side.
- R3: A payload byte accepted on `tx_in_*` (valid and ready both high at an edge) appears on `tx_out_data` with `tx_out_valid` high one cycle later. Bytes keep their order, and `tx_out_last` is low on payload bytes.
- R4: The trailer bytes follow the last payload byte on consecutive cycles, most significant byte first: one byte for `CRC_W`=8 and two for 16. `tx_out_last` is high only on the final trailer byte.
- R5: `tx_in_ready` is low for exactly `CRC_W`/8 cycles after the cycle in which a last byte is accepted, and high at all other times. When frames are sent back to back, `tx_out_valid` has no gap.
- R6: The running register reloads its start value on the cycle after a frame's last payload byte. The next frame's checksum therefore covers only its own bytes, even when that frame starts on the first cycle it is allowed to.
- R7: A frame-start pulse (`tx_frame_start` / `rx_frame_start`) discards any partial checksum. A byte that is valid in the same cycle becomes the first byte of the new frame, computed from the start value. On the receive side the pulse also abandons any trailer in progress.
- R8: On the receive side, the byte flagged with `rx_in_last` is the final payload byte, and the next `CRC_W`/8 valid bytes are the trailer, most significant byte first. `rx_done` pulses high for one cycle, on the cycle after the final trailer byte. In that same cycle `rx_ok` is 1 exactly when every trailer byte equals the checksum computed over the payload.
- R9: `rx_ok` holds its value until the next payload byte is accepted or `rx_frame_start` pulses, and then it clears. At all other times `rx_done` is low.
- R10: A mismatch in any single trailer byte, high or low, gives `rx_ok` = 0 with `rx_done` high.
- R11: After synchronous reset, `tx_out_valid`, `tx_out_last`, `rx_done` and `rx_ok` are 0 and `tx_in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_frame_start | input | 1 | Restart the transmit checksum |
| tx_in_valid | input | 1 | Transmit payload byte valid |
| tx_in_data | input | 8 | Transmit payload byte |
| tx_in_last | input | 1 | Marks the final payload byte of a frame |
| tx_in_ready | output | 1 | Low while the trailer is being emitted |
| tx_out_valid | output | 1 | Outgoing byte valid |
| tx_out_data | output | 8 | Outgoing payload or trailer byte |
| tx_out_last | output | 1 | Marks the final trailer byte |
| rx_frame_start | input | 1 | Restart the receive checksum and abandon any trailer |
| rx_in_valid | input | 1 | Received byte valid |
| rx_in_data | input | 8 | Received payload or trailer byte |
| rx_in_last | input | 1 | Marks the final payload byte |
| rx_done | output | 1 | One-cycle strobe after the final trailer byte |
| rx_ok | output | 1 | Checksum match result |

## Verification
Two functions can fall in the same cycle. The first is a frame-start pulse arriving together with a valid payload byte. The bench provokes it by sending a partial frame with no last flag and then pulsing frame start alongside the first byte of a real frame. The case passes when the transmitted trailer, or `rx_ok`, matches a checksum taken over the post-pulse bytes only. The second is the automatic register reload landing in the cycle just before the next frame's first byte. Back-to-back frames provoke it, and the bench judges it by a gapless output stream in which both trailers are correct.

// File: rtl/crc_frame_pkg.sv
package crc_frame_pkg;

  function automatic logic [15:0] crc_poly(input int width);
    return (width == 16) ? 16'h1021 : 16'h0007;
  endfunction

  function automatic logic [15:0] crc_init(input int width);
    return (width == 16) ? 16'hFFFF : 16'h0000;
  endfunction

  function automatic int trailer_bytes(input int width);
    return width / 8;
  endfunction

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic [W-1:0] crc_in,
  input  logic [7:0]   data_in,
  output logic [W-1:0] crc_out
);
  // Eight MSB-first steps, unrolled so that one byte is absorbed per clock.
  always_comb begin
    logic [W-1:0] r;
    r = crc_in ^ (W'(data_in) << (W - 8));
    for (int k = 0; k < 8; k++) begin
      r = r[W-1] ? ((r << 1) ^ POLY) : (r << 1);
    end
    crc_out = r;
  end
endmodule

// File: rtl/crc_tx_framer.sv
module crc_tx_framer #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] INIT = '0,
  parameter int           TB   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int CW = $clog2(TB + 1);

  logic [W-1:0]  crc_q;
  logic [W-1:0]  tail_q;
  logic [CW-1:0] tail_cnt;
  logic [W-1:0]  crc_seed;
  logic [W-1:0]  crc_next;
  logic          in_fire;

  assign in_ready = (tail_cnt == '0);
  assign in_fire  = in_valid && in_ready;
  assign crc_seed = frame_start ? INIT : crc_q;

  crc_byte_step #(.W(W), .POLY(POLY)) u_step (
    .crc_in (crc_seed),
    .data_in(in_data),
    .crc_out(crc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q     <= INIT;
      tail_q    <= '0;
      tail_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (in_fire) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        crc_q     <= in_last ? INIT : crc_next;
        if (in_last) begin
          tail_q   <= crc_next;
          tail_cnt <= CW'(TB);
        end
      end else begin
        if (frame_start) crc_q <= INIT;
        if (tail_cnt != '0) begin
          out_valid <= 1'b1;
          out_data  <= tail_q[W-1 -: 8];
          out_last  <= (tail_cnt == CW'(1));
          tail_q    <= tail_q << 8;
          tail_cnt  <= tail_cnt - CW'(1);
        end
      end
    end
  end

  AST_LAST_PAYLOAD_FWD: assert property (@(posedge clk) disable iff (rst)
    (in_fire && in_last) |=> (out_valid && !out_last && !in_ready)); // R4
  AST_TAIL_GAPLESS: assert property (@(posedge clk) disable iff (rst)
    (!in_ready) |=> out_valid); // R5
  AST_TX_CRC_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (in_fire && in_last) |=> (crc_q == INIT)); // R6
  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R4
endmodule

// File: rtl/crc_rx_checker.sv
module crc_rx_checker #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] INIT = '0,
  parameter int           TB   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       done,
  output logic       ok
);
  localparam int CW = $clog2(TB + 1);

  logic [W-1:0]  crc_q;
  logic [W-1:0]  calc_q;
  logic [CW-1:0] tail_cnt;
  logic          mism_q;
  logic [W-1:0]  crc_seed;
  logic [W-1:0]  crc_next;
  logic          pay_fire;
  logic          tail_fire;
  logic          tail_bad;

  assign pay_fire  = in_valid && ((tail_cnt == '0) || frame_start);
  assign tail_fire = in_valid && (tail_cnt != '0) && !frame_start;
  assign crc_seed  = frame_start ? INIT : crc_q;
  assign tail_bad  = (in_data != calc_q[W-1 -: 8]);

  crc_byte_step #(.W(W), .POLY(POLY)) u_step (
    .crc_in (crc_seed),
    .data_in(in_data),
    .crc_out(crc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q    <= INIT;
      calc_q   <= '0;
      tail_cnt <= '0;
      mism_q   <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (frame_start) begin
        crc_q    <= INIT;
        tail_cnt <= '0;
        ok       <= 1'b0;
      end
      if (pay_fire) begin
        ok    <= 1'b0;
        crc_q <= in_last ? INIT : crc_next;
        if (in_last) begin
          calc_q   <= crc_next;
          tail_cnt <= CW'(TB);
          mism_q   <= 1'b0;
        end
      end else if (tail_fire) begin
        calc_q   <= calc_q << 8;
        tail_cnt <= tail_cnt - CW'(1);
        mism_q   <= mism_q | tail_bad;
        if (tail_cnt == CW'(1)) begin
          done <= 1'b1;
          ok   <= !(mism_q | tail_bad);
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_OK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !in_valid) |=> $stable(ok)); // R9
  AST_RX_CRC_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (pay_fire && in_last) |=> (crc_q == INIT)); // R6
  AST_OK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !ok); // R9
endmodule

// File: rtl/crc_frame_engine.sv
module crc_frame_engine #(
  parameter int CRC_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_frame_start,
  input  logic       tx_in_valid,
  input  logic [7:0] tx_in_data,
  input  logic       tx_in_last,
  output logic       tx_in_ready,
  output logic       tx_out_valid,
  output logic [7:0] tx_out_data,
  output logic       tx_out_last,
  input  logic       rx_frame_start,
  input  logic       rx_in_valid,
  input  logic [7:0] rx_in_data,
  input  logic       rx_in_last,
  output logic       rx_done,
  output logic       rx_ok
);
  import crc_frame_pkg::*;

  localparam logic [CRC_W-1:0] POLY = CRC_W'(crc_poly(CRC_W));
  localparam logic [CRC_W-1:0] INIT = CRC_W'(crc_init(CRC_W));
  localparam int               TB   = trailer_bytes(CRC_W);

  crc_tx_framer #(.W(CRC_W), .POLY(POLY), .INIT(INIT), .TB(TB)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .frame_start(tx_frame_start),
    .in_valid   (tx_in_valid),
    .in_data    (tx_in_data),
    .in_last    (tx_in_last),
    .in_ready   (tx_in_ready),
    .out_valid  (tx_out_valid),
    .out_data   (tx_out_data),
    .out_last   (tx_out_last)
  );

  crc_rx_checker #(.W(CRC_W), .POLY(POLY), .INIT(INIT), .TB(TB)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .frame_start(rx_frame_start),
    .in_valid   (rx_in_valid),
    .in_data    (rx_in_data),
    .in_last    (rx_in_last),
    .done       (rx_done),
    .ok         (rx_ok)
  );
endmodule

// File: tb/crc_frame_engine_test.sv
module crc_frame_engine_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic fs, tv, tl, trdy, ov, ol, rfs, rv, rl, rdone, rok;
  logic [7:0] td, od, rd;
  logic fs8, tv8, tl8, trdy8, ov8, ol8, rdone8, rok8;
  logic [7:0] td8, od8;
  logic z1 = 1'b0;
  logic [7:0] z8 = 8'h00;

  crc_frame_engine #(.CRC_W(16)) uut (
    .clk(clk), .rst(rst), .tx_frame_start(fs), .tx_in_valid(tv), .tx_in_data(td),
    .tx_in_last(tl), .tx_in_ready(trdy), .tx_out_valid(ov), .tx_out_data(od),
    .tx_out_last(ol), .rx_frame_start(rfs), .rx_in_valid(rv), .rx_in_data(rd),
    .rx_in_last(rl), .rx_done(rdone), .rx_ok(rok));

  crc_frame_engine #(.CRC_W(8)) uut8 (
    .clk(clk), .rst(rst), .tx_frame_start(fs8), .tx_in_valid(tv8), .tx_in_data(td8),
    .tx_in_last(tl8), .tx_in_ready(trdy8), .tx_out_valid(ov8), .tx_out_data(od8),
    .tx_out_last(ol8), .rx_frame_start(z1), .rx_in_valid(z1), .rx_in_data(z8),
    .rx_in_last(z1), .rx_done(rdone8), .rx_ok(rok8));

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  logic [7:0] msg [16];
  logic [7:0] cap_d [64]; logic cap_l [64]; int cap_c [64]; int cap_n = 0;
  logic [7:0] cap8_d [16]; logic cap8_l [16]; int cap8_n = 0;
  logic [7:0] exp_d [64]; logic exp_l [64]; int exp_n = 0;

  always @(negedge clk) begin
    if (!rst && ov && cap_n < 64) begin
      cap_d[cap_n] = od; cap_l[cap_n] = ol; cap_c[cap_n] = cyc; cap_n++;
    end
    if (!rst && ov8 && cap8_n < 16) begin
      cap8_d[cap8_n] = od8; cap8_l[cap8_n] = ol8; cap8_n++;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int w, input int n);
    logic [15:0] c;
    logic [15:0] poly;
    logic top;
    c = (w == 16) ? 16'hFFFF : 16'h0000;
    poly = (w == 16) ? 16'h1021 : 16'h0007;
    for (int i = 0; i < n; i++) begin
      c = c ^ ((w == 16) ? {msg[i], 8'h00} : {8'h00, msg[i]});
      for (int k = 0; k < 8; k++) begin
        top = (w == 16) ? c[15] : c[7];
        c = c << 1;
        if (top) c = c ^ poly;
        if (w == 8) c = c & 16'h00FF;
      end
    end
    return c;
  endfunction

  task automatic load_ascii_kat();
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
  endtask

  task automatic load_pattern(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) msg[i] = seed ^ 8'(i * 37);
  endtask

  task automatic exp_add(input int n, input bit with_tail);
    logic [15:0] c;
    c = ref_crc(16, n);
    for (int i = 0; i < n; i++) begin
      exp_d[exp_n] = msg[i]; exp_l[exp_n] = 1'b0; exp_n++;
    end
    if (with_tail) begin
      exp_d[exp_n] = c[15:8]; exp_l[exp_n] = 1'b0; exp_n++;
      exp_d[exp_n] = c[7:0];  exp_l[exp_n] = 1'b1; exp_n++;
    end
  endtask

  task automatic tx_send(input int n, input bit start_first, input bit with_last);
    for (int i = 0; i < n; i++) begin
      while (!trdy) @(negedge clk);
      fs = start_first && (i == 0);
      tv = 1'b1; td = msg[i]; tl = with_last && (i == n - 1);
      @(negedge clk);
    end
    tv = 1'b0; tl = 1'b0; fs = 1'b0;
  endtask

  task automatic compare_stream(input string req);
    check_eq(req, "output byte count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check_eq(req, $sformatf("byte %0d", i), cap_d[i], exp_d[i]);
      check_eq(req, $sformatf("last flag %0d", i), cap_l[i], exp_l[i]);
    end
  endtask

  task automatic rx_send(input int n, input bit start_first, input bit with_last,
                         input logic [15:0] tr, input int ntr);
    for (int i = 0; i < n; i++) begin
      rfs = start_first && (i == 0);
      rv = 1'b1; rd = msg[i]; rl = with_last && (i == n - 1);
      @(negedge clk);
    end
    rfs = 1'b0; rl = 1'b0;
    for (int j = 0; j < ntr; j++) begin
      rv = 1'b1; rd = (j == 0) ? tr[15:8] : tr[7:0];
      @(negedge clk);
    end
    rv = 1'b0;
  endtask

  task automatic t_reset();
    check_eq("R11", "tx_out_valid after reset", ov, 0);
    check_eq("R11", "tx_out_last after reset", ol, 0);
    check_eq("R11", "tx_in_ready after reset", trdy, 1);
    check_eq("R11", "rx_done after reset", rdone, 0);
    check_eq("R11", "rx_ok after reset", rok, 0);
  endtask

  task automatic t_kat16_tx();
    cap_n = 0; exp_n = 0;
    load_ascii_kat();
    exp_add(9, 1);
    tx_send(9, 0, 1);
    check_eq("R5", "ready low 1st cycle after last", trdy, 0);
    @(negedge clk);
    check_eq("R5", "ready low 2nd cycle after last", trdy, 0);
    @(negedge clk);
    check_eq("R5", "ready back high", trdy, 1);
    repeat (3) @(negedge clk);
    compare_stream("R3");
    check_eq("R2", "trailer high byte", cap_d[9], 8'h29);
    check_eq("R4", "trailer low byte", cap_d[10], 8'hB1);
    check_eq("R4", "final byte last flag", cap_l[10], 1);
  endtask

  task automatic t_kat8_tx();
    cap8_n = 0;
    load_ascii_kat();
    for (int i = 0; i < 9; i++) begin
      tv8 = 1'b1; td8 = msg[i]; tl8 = (i == 8);
      @(negedge clk);
    end
    tv8 = 1'b0; tl8 = 1'b0;
    check_eq("R5", "8-bit ready low after last", trdy8, 0);
    @(negedge clk);
    check_eq("R5", "8-bit ready high", trdy8, 1);
    repeat (3) @(negedge clk);
    check_eq("R1", "8-bit output count", cap8_n, 10);
    check_eq("R1", "8-bit trailer", cap8_d[9], 8'hF4);
    check_eq("R1", "8-bit trailer last flag", cap8_l[9], 1);
    check_eq("R3", "8-bit payload byte 0", cap8_d[0], 8'h31);
  endtask

  task automatic t_back_to_back();
    cap_n = 0; exp_n = 0;
    load_pattern(5, 8'hA5); exp_add(5, 1); tx_send(5, 0, 1);
    load_pattern(3, 8'h3C); exp_add(3, 1); tx_send(3, 0, 1);
    repeat (5) @(negedge clk);
    compare_stream("R6");
    check_eq("R5", "gapless back-to-back span", cap_c[cap_n-1] - cap_c[0], cap_n - 1);
  endtask

  task automatic t_tx_restart();
    cap_n = 0; exp_n = 0;
    load_pattern(3, 8'hF0); exp_add(3, 0); tx_send(3, 0, 0);
    load_pattern(4, 8'h17); exp_add(4, 1); tx_send(4, 1, 1);
    repeat (5) @(negedge clk);
    compare_stream("R7");
  endtask

  task automatic t_rx_good_and_hold();
    load_pattern(6, 8'h5A);
    rx_send(6, 1, 1, ref_crc(16, 6), 2);
    check_eq("R8", "done strobe after good frame", rdone, 1);
    check_eq("R8", "ok after good frame", rok, 1);
    @(negedge clk);
    check_eq("R9", "done drops after one cycle", rdone, 0);
    repeat (3) @(negedge clk);
    check_eq("R9", "ok held while idle", rok, 1);
    check_eq("R9", "done stays low while idle", rdone, 0);
    load_pattern(1, 8'h11);
    rx_send(1, 0, 0, 16'h0000, 0);
    check_eq("R9", "ok cleared by next payload byte", rok, 0);
  endtask

  task automatic t_rx_bad();
    logic [15:0] c;
    load_pattern(4, 8'hC3);
    c = ref_crc(16, 4);
    rx_send(4, 1, 1, c ^ 16'h0100, 2);
    check_eq("R10", "done on bad high byte", rdone, 1);
    check_eq("R10", "ok on bad high byte", rok, 0);
    rx_send(4, 0, 1, c ^ 16'h0001, 2);
    check_eq("R10", "done on bad low byte", rdone, 1);
    check_eq("R10", "ok on bad low byte", rok, 0);
    rx_send(4, 0, 1, c, 2);
    check_eq("R6", "ok on following good frame", rok, 1);
  endtask

  task automatic t_rx_restart();
    load_pattern(2, 8'h99);
    rx_send(2, 0, 0, 16'h0000, 0);
    load_pattern(5, 8'h42);
    rx_send(5, 1, 1, ref_crc(16, 5), 2);
    check_eq("R7", "done after restarted frame", rdone, 1);
    check_eq("R7", "ok uses only post-restart bytes", rok, 1);
  endtask

  task automatic t_rx_kat();
    load_ascii_kat();
    rx_send(9, 1, 1, 16'h29B1, 2);
    check_eq("R2", "receive accepts 0x29B1 trailer", rok, 1);
    check_eq("R8", "receive done for known answer", rdone, 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    rst = 1'b1;
    fs = 0; tv = 0; tl = 0; td = 0; rfs = 0; rv = 0; rl = 0; rd = 0;
    fs8 = 0; tv8 = 0; tl8 = 0; td8 = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_kat16_tx();
    t_kat8_tx();
    t_back_to_back();
    t_tx_restart();
    t_rx_good_and_hold();
    t_rx_bad();
    t_rx_restart();
    t_rx_kat();
    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end
endmodule